// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Core

This block is a small processor core that executes each instruction as a fixed series of register transfers. The phases are fetch, decode, execute, memory and write-back. A program counter feeds an address register. Memory words land in an instruction register or a data register. Two operand latches feed a 32-bit adder. The core knows three instructions: a register-to-register add, a load from a base register plus a signed 16-bit offset, and a branch that jumps when a register is nonzero. Any other opcode does nothing.

A single synchronous memory port serves both instruction and data reads. The core drives an address and a read strobe. The memory returns the word on the clock edge after the strobe. No instruction writes to memory, so memory stays constant while a program runs. The register file can be observed from outside through the addresses of later loads and through the fetch addresses that branches select.

Instruction word layout, most significant bit first: opcode in [31:26], first source register in [25:21], second source register in [20:16], add destination in [15:11], and a 16-bit immediate in [15:0]. The load destination is in [20:16].

Opcodes: add = 6'h01, load = 6'h23, branch-if-nonzero = 6'h05.

Top module: `mc_cpu`

## Requirements
- R1: While rst_n is low, mem_rd stays low. Reset clears the program counter and all registers to zero and puts the core in its fetch phase. The first read after reset fetches address 0, one cycle after the first rising edge with rst_n high.
- R2: Each instruction starts with a read strobe whose address equals the program counter. The word returned on the next edge becomes the instruction.
- R3: Decode advances the program counter by 4. When an instruction does not branch, the next fetch address is 4 above the previous one.
- R4: Add (6'h01) writes rs1 + rs2, modulo 2^32, into register [15:11]. One add takes 6 cycles from the start of one fetch phase to the next.
- R5: Load (6'h23) reads the word at rs1 + sign-extended [15:0] and writes it into register [20:16]. The data read occurs 5 cycles after the fetch phase starts, and one load takes 8 cycles.
- R6: Branch (6'h05) tests register [25:21]. If it is nonzero, the next fetch is at (fetch address + 4) + sign-extended [15:0]; otherwise the next fetch is at fetch address + 4. The branch takes 6 cycles in both cases.
- R7: Register 0 always reads as zero, and an add that targets register 0 changes nothing.
- R8: Any other opcode is a no-op. It takes 4 cycles and the next fetch is at fetch address + 4.
- R9: The read strobe is never high in two consecutive cycles, because each read has a wait cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 32 | Byte address of the memory read |
| mem_rd | output | 1 | Read strobe; data is expected on the following edge |
| mem_rdata | input | 32 | Word returned by the memory |

## Verification
The assertions rely on one property of the memory: it presents the addressed word on the edge after the strobe and holds it until the next read. The latches are checked against that behaviour. The bench memory is a registered array indexed by address bits [9:2] that updates only on strobe cycles, so it meets this exactly. No instruction writes memory, so the expected read sequence depends only on the loaded image. The random programs draw their opcodes only from the three known ones and from explicit unknown codes. Branch offsets are kept word-aligned, so every fetch lands on a word boundary.

// File: rtl/mc_cpu.sv
module mc_cpu #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] mem_addr,
  output logic            mem_rd,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam int RW = $clog2(NREG);
  localparam logic [5:0] OP_ADD  = 6'h01;
  localparam logic [5:0] OP_LOAD = 6'h23;
  localparam logic [5:0] OP_BNEZ = 6'h05;

  typedef enum logic [3:0] {
    S_IF, S_IFR, S_IFL, S_ID, S_EX, S_MEMR, S_MEML, S_BRM, S_WB
  } st_t;

  st_t st;
  logic [XLEN-1:0] pc, mar, mdr, ir, a, b, alu;
  logic            cond;
  logic [XLEN-1:0] rf [NREG];

  wire [5:0]      op     = ir[31:26];
  wire [RW-1:0]   rs1    = ir[21+RW-1:21];
  wire [RW-1:0]   rs2    = ir[16+RW-1:16];
  wire [RW-1:0]   rd_add = ir[11+RW-1:11];
  wire [XLEN-1:0] imm    = {{(XLEN-16){ir[15]}}, ir[15:0]};
  wire            known  = (op == OP_ADD) || (op == OP_LOAD) || (op == OP_BNEZ);

  wire [XLEN-1:0] rs1_val = (rs1 == '0) ? '0 : rf[rs1];
  wire [XLEN-1:0] rs2_val = (rs2 == '0) ? '0 : rf[rs2];

  wire            is_load = (op == OP_LOAD);
  wire [RW-1:0]   wb_idx  = is_load ? rs2 : rd_add;
  wire [XLEN-1:0] wb_data = is_load ? mdr : alu;
  wire            wb_en   = (st == S_WB) && (wb_idx != '0);

  assign mem_addr = mar;
  assign mem_rd   = (st == S_IFR) || (st == S_MEMR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IF;
      pc   <= '0;
      mar  <= '0;
      mdr  <= '0;
      ir   <= '0;
      a    <= '0;
      b    <= '0;
      alu  <= '0;
      cond <= 1'b0;
    end else begin
      case (st)
        S_IF: begin
          mar <= pc;
          st  <= S_IFR;
        end
        S_IFR: st <= S_IFL;
        S_IFL: begin
          ir <= mem_rdata;
          st <= S_ID;
        end
        S_ID: begin
          a  <= rs1_val;
          b  <= rs2_val;
          pc <= pc + XLEN'(4);
          st <= known ? S_EX : S_IF;
        end
        S_EX: begin
          case (op)
            OP_ADD: begin
              alu <= a + b;
              st  <= S_WB;
            end
            OP_LOAD: begin
              mar <= a + imm;
              st  <= S_MEMR;
            end
            default: begin
              alu  <= pc + imm;
              cond <= (a != '0);
              st   <= S_BRM;
            end
          endcase
        end
        S_MEMR: st <= S_MEML;
        S_MEML: begin
          mdr <= mem_rdata;
          st  <= S_WB;
        end
        S_BRM: begin
          if (cond) pc <= alu;
          st <= S_IF;
        end
        S_WB:    st <= S_IF;
        default: st <= S_IF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wb_en) begin
      rf[wb_idx] <= wb_data;
    end
  end
endmodule

// File: rtl/mc_cpu_chk.sv
module mc_cpu_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            is_ifr,
  input logic            is_ifl,
  input logic            is_dec,
  input logic            is_brm,
  input logic            rs1_zero,
  input logic            mem_rd,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_rdata,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ir,
  input logic [XLEN-1:0] a
);
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    is_ifr |-> (mem_rd && mem_addr == pc)); // R2
  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    is_ifl |=> (ir == $past(mem_rdata))); // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    is_dec |=> (pc == $past(pc) + XLEN'(4))); // R3
  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (is_dec && rs1_zero) |=> (a == '0)); // R7
  AST_BRANCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_brm && a == '0) |=> $stable(pc)); // R6
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd); // R9
endmodule

bind mc_cpu mc_cpu_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .is_ifr(st == S_IFR), .is_ifl(st == S_IFL), .is_dec(st == S_ID),
  .is_brm(st == S_BRM), .rs1_zero(ir[25:21] == 5'd0),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
  .pc(pc), .ir(ir), .a(a)
);

// File: tb/mc_cpu_tb_top.sv
module mc_cpu_tb_top;
  localparam int MAXE = 60;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] mem_addr, mem_rdata;
  logic mem_rd;
  logic [31:0] mem [256];

  int tests = 0, fails = 0;
  int cyc = 0, n_seen = 0, b2b = 0;
  bit prev_rd = 1'b0;

  int          ev_cyc  [MAXE];
  logic [31:0] ev_addr [MAXE];
  bit          ev_fetch[MAXE];
  string       ev_req  [MAXE];

  always #2 clk = ~clk;

  mc_cpu dut_i (.clk(clk), .rst_n(rst_n), .mem_addr(mem_addr),
                .mem_rd(mem_rd), .mem_rdata(mem_rdata));

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
  end

  function automatic logic [31:0] enc_add(int rd, int rs1, int rs2);
    return {6'h01, 5'(rs1), 5'(rs2), 5'(rd), 11'd0};
  endfunction
  function automatic logic [31:0] enc_ld(int rd, int rs1, int imm);
    return {6'h23, 5'(rs1), 5'(rd), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_bnez(int rs1, int imm);
    return {6'h05, 5'(rs1), 5'd0, 16'(imm)};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build_expected();
    logic [31:0] r [32];
    logic [31:0] pc = 0, ins, ea, sx;
    int s = 0, n = 0;
    string nxt = "R1";
    for (int i = 0; i < 32; i++) r[i] = 0;
    while (n < MAXE) begin
      ev_cyc[n] = s + 1; ev_addr[n] = pc; ev_fetch[n] = 1'b1; ev_req[n] = nxt; n++;
      ins = mem[pc[9:2]];
      pc = pc + 4;
      sx = {{16{ins[15]}}, ins[15:0]};
      case (ins[31:26])
        6'h01: begin
          if (ins[15:11] != 0) r[ins[15:11]] = r[ins[25:21]] + r[ins[20:16]];
          s += 6; nxt = "R4";
        end
        6'h23: begin
          ea = r[ins[25:21]] + sx;
          if (n < MAXE) begin
            ev_cyc[n] = s + 5; ev_addr[n] = ea; ev_fetch[n] = 1'b0; ev_req[n] = "R5"; n++;
          end
          if (ins[20:16] != 0) r[ins[20:16]] = mem[ea[9:2]];
          s += 8; nxt = "R5";
        end
        6'h05: begin
          if (r[ins[25:21]] != 0) pc = pc + sx;
          s += 6; nxt = "R6";
        end
        default: begin s += 4; nxt = "R8"; end
      endcase
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(!mem_rd, "R1", "strobe during reset", {31'd0, mem_rd}, 32'd0);
      prev_rd = 1'b0;
    end else begin
      if (mem_rd && prev_rd) b2b++;
      prev_rd = mem_rd;
      if (mem_rd && n_seen < MAXE) begin
        check(mem_addr == ev_addr[n_seen], ev_fetch[n_seen] ? "R2" : "R5",
              "read address", mem_addr, ev_addr[n_seen]);
        check(cyc == ev_cyc[n_seen], ev_req[n_seen], "read cycle", cyc, ev_cyc[n_seen]);
        n_seen++;
      end
    end
  end

  task automatic run_phase(string name);
    int t = 0;
    build_expected();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_seen = 0;
    rst_n = 1'b1;
    while (n_seen < MAXE && t < 3000) begin @(negedge clk); t++; end
    if (n_seen < MAXE) begin
      fails++; tests++;
      $display("FAIL R1 watchdog in %s: actual %0d expected %0d reads", name, n_seen, MAXE);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = 32'hFC00_0000;
    mem[0]  = enc_ld(1, 0, 'h200);   // R7 base r0
    mem[1]  = enc_ld(2, 0, 'h204);
    mem[2]  = enc_add(3, 1, 2);      // R4
    mem[3]  = enc_ld(4, 3, 0);
    mem[4]  = enc_add(0, 1, 2);      // R7 write ignored
    mem[5]  = enc_ld(5, 0, 'h100);
    mem[6]  = 32'hFC00_1234;         // R8 unknown
    mem[7]  = enc_bnez(0, 8);        // R6 not taken
    mem[8]  = enc_bnez(1, 8);        // R6 taken forward
    mem[11] = enc_ld(7, 1, -4);      // R5 negative offset
    mem[12] = enc_bnez(1, -52);      // R6 taken backward to 0
    mem[128] = 32'h10;
    mem[129] = 32'h20;
    run_phase("directed");

    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        int k = $urandom % 8;
        if (i >= 64) mem[i] = $urandom;
        else if (k < 3) mem[i] = enc_add($urandom % 32, $urandom % 32, $urandom % 32);
        else if (k < 5) mem[i] = enc_ld($urandom % 32, $urandom % 32, int'($urandom % 1024) - 512);
        else if (k < 7) mem[i] = enc_bnez($urandom % 32, (int'($urandom % 16) - 6) * 4);
        else mem[i] = {6'h3E, 26'($urandom)};
      end
      run_phase("random");
    end

    check(b2b == 0, "R9", "back-to-back strobes", b2b, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule